// File: doc/BRIEF.md
# ECC-Protected Byte-Writable SRAM Controller

This block wraps an on-chip storage array that keeps data as 64-bit words, each stored with 8 check bits of a single-error-correcting, double-error-detecting Hamming code. It serves one request at a time from a simple valid/ready request bus and returns a single-cycle response pulse. Reads return corrected data and raise a corrected-error or uncorrectable-error flag alongside the response.

Writes carry a byte mask. A write that sets every mask bit is encoded and stored at once. Any narrower write becomes a read-modify-write: the stored word is read, corrected, merged with the enabled bytes, re-encoded and written back. A single-bit fault in the old word is therefore scrubbed. If the old word holds an uncorrectable error, the write is abandoned and the word is left as it was.

The array appears in the address map either as one window of DEPTH words at a programmable base, or as two half-size windows with independent bases. Requests that fall outside every window are accepted and dropped. A backdoor port can flip any single stored bit for fault injection.

Top module: `sram_ecc_ctrl`

## Requirements
- R1: A claimed read accepted at clock edge n raises rsp_valid_o for exactly one cycle, beginning at edge n+1. In that cycle rsp_rdata_o carries the stored 64-bit word, and req_ready_o is low in the cycle between edge n and edge n+1.
- R2: A claimed write with req_be_i equal to 8'hFF is stored without a read. rsp_valid_o is high in the cycle starting at the accepting edge, with both error flags low and req_ready_o high. This holds even when the old stored word was corrupt.
- R3: A claimed write with any req_be_i bit clear is a read-modify-write. Byte b (bits 8b+7..8b) takes the new data where req_be_i[b] is 1 and keeps the old value elsewhere. req_ready_o is low for one cycle, and the response follows one edge later, as for a read.
- R4: A read of a word with one flipped stored bit returns the original data with corr_err_o high and uncorr_err_o low. This applies to any of the 72 codeword bits, numbered 0 to 71 on the backdoor port.
- R5: A read of a word with two flipped stored bits raises uncorr_err_o and keeps corr_err_o low.
- R6: A read-modify-write on a word with one flipped bit raises corr_err_o and stores the corrected, merged word, so a later read shows no error flag.
- R7: A read-modify-write on a word with two flipped bits raises uncorr_err_o and leaves the stored codeword unchanged.
- R8: A request whose address hits no window is accepted, produces no response and changes no stored word.
- R9: With split_i low, the window covers DEPTH*8 bytes at base0_i, which is aligned to that size. Address bits [IDX_W+2:3] select the word, and bits [2:0] are ignored.
- R10: With split_i high, base0_i maps words 0..DEPTH/2-1 and base1_i maps words DEPTH/2..DEPTH-1. Each window covers DEPTH*4 bytes aligned to its size, and the base0_i window wins when the two overlap.
- R11: While rst_ni is low, req_ready_o is high and rsp_valid_o, corr_err_o and uncorr_err_o are low.
- R12: corr_err_o and uncorr_err_o are never high together, and are only ever high together with rsp_valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| split_i | input | 1 | 1: two half-size windows, 0: one full window |
| base0_i | input | ADDR_W | Base of the full window, or of the lower half |
| base1_i | input | ADDR_W | Base of the upper half in split mode |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller can accept a request |
| req_write_i | input | 1 | 1: write, 0: read |
| req_addr_i | input | ADDR_W | Byte address |
| req_be_i | input | 8 | Byte enables for writes |
| req_wdata_i | input | 64 | Write data |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_rdata_o | output | 64 | Read data (zero on write responses) |
| corr_err_o | output | 1 | A single-bit error was corrected |
| uncorr_err_o | output | 1 | An uncorrectable error was detected |
| bd_flip_i | input | 1 | Backdoor: flip one stored bit this cycle |
| bd_idx_i | input | IDX_W | Backdoor word index |
| bd_bit_i | input | 7 | Backdoor codeword bit (0..71) |

## Verification
The assertions rely on three things about the inputs: a backdoor flip is never issued in the same cycle as an array write to the same word, the base inputs are aligned and held steady while a request is in flight, and only one request is presented at a time. The stimulus meets all three. Bases and split_i change only between requests, flips are issued only while the bus is idle, and each request is deasserted before the next one is presented. This keeps the latency and flag properties meaningful across both address modes.

// File: rtl/sram_ecc_pkg.sv
package sram_ecc_pkg;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned CODE_W = 72;

  typedef logic [CODE_W-1:0] code_t;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_MERGE} state_e;

  function automatic logic is_pow2(int unsigned p);
    return (p & (p - 1)) == 0;
  endfunction

  // codeword: bit 0 overall parity, bits 2^k Hamming, rest data in order
  function automatic code_t ecc_encode(logic [DATA_W-1:0] d);
    code_t c;
    int unsigned k;
    logic x;
    c = '0;
    k = 0;
    for (int unsigned p = 1; p < CODE_W; p++) begin
      if (!is_pow2(p)) begin
        c[p] = d[k];
        k++;
      end
    end
    for (int unsigned b = 0; b < 7; b++) begin
      x = 1'b0;
      for (int unsigned p = 1; p < CODE_W; p++) begin
        if (p[b]) x ^= c[p];
      end
      c[1 << b] = x;
    end
    c[0] = ^c[CODE_W-1:1];
    return c;
  endfunction

  function automatic logic [6:0] ecc_syndrome(code_t c);
    logic [6:0] s;
    s = '0;
    for (int unsigned p = 1; p < CODE_W; p++) begin
      if (c[p]) s ^= 7'(p);
    end
    return s;
  endfunction

  function automatic logic [DATA_W-1:0] ecc_extract(code_t c);
    logic [DATA_W-1:0] d;
    int unsigned k;
    d = '0;
    k = 0;
    for (int unsigned p = 1; p < CODE_W; p++) begin
      if (!is_pow2(p)) begin
        d[k] = c[p];
        k++;
      end
    end
    return d;
  endfunction
endpackage

// File: rtl/sram_ecc_region_dec.sv
module sram_ecc_region_dec #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              split_i,
  input  logic [ADDR_W-1:0] base0_i,
  input  logic [ADDR_W-1:0] base1_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int unsigned OFF_W  = IDX_W + 3;
  localparam int unsigned HOFF_W = OFF_W - 1;

  logic [1:0]       hit_h;
  logic [IDX_W-2:0] off_h;
  logic             hit_full;
  logic             unused_lsb;

  assign off_h    = addr_i[HOFF_W-1:3];
  assign hit_full = addr_i[ADDR_W-1:OFF_W] == base0_i[ADDR_W-1:OFF_W];

  for (genvar r = 0; r < 2; r++) begin : g_half
    logic [ADDR_W-1:0] base;
    assign base     = (r == 0) ? base0_i : base1_i;
    assign hit_h[r] = addr_i[ADDR_W-1:HOFF_W] == base[ADDR_W-1:HOFF_W];
  end

  always_comb begin
    if (split_i) begin
      hit_o = |hit_h;
      idx_o = hit_h[0] ? {1'b0, off_h} : {1'b1, off_h};
    end else begin
      hit_o = hit_full;
      idx_o = addr_i[OFF_W-1:3];
    end
  end

  assign unused_lsb = ^{addr_i[2:0], base0_i[HOFF_W-1:0], base1_i[HOFF_W-1:0]};
endmodule

// File: rtl/sram_ecc_array.sv
module sram_ecc_array
  import sram_ecc_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  code_t            wr_code_i,
  input  logic             rd_en_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output code_t            rd_code_o,
  input  logic             bd_flip_i,
  input  logic [IDX_W-1:0] bd_idx_i,
  input  logic [6:0]       bd_bit_i
);
  code_t mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (bd_flip_i) mem[bd_idx_i][bd_bit_i] <= ~mem[bd_idx_i][bd_bit_i];
    if (wr_en_i)   mem[wr_idx_i] <= wr_code_i;
    if (rd_en_i)   rd_code_o <= mem[rd_idx_i];
  end
endmodule

// File: rtl/sram_ecc_dec.sv
module sram_ecc_dec
  import sram_ecc_pkg::*;
(
  input  code_t              code_i,
  output logic [DATA_W-1:0]  data_o,
  output logic               single_o,
  output logic               double_o
);
  logic [6:0] syn;
  logic       par;
  code_t      fixed;

  always_comb begin
    syn      = ecc_syndrome(code_i);
    par      = ^code_i;
    fixed    = code_i;
    single_o = 1'b0;
    double_o = 1'b0;
    if (par) begin
      // odd weight: one flip, unless the syndrome points past the word
      if (syn < 7'd72) begin
        single_o   = 1'b1;
        fixed[syn] = ~fixed[syn];
      end else begin
        double_o = 1'b1;
      end
    end else if (syn != '0) begin
      double_o = 1'b1;
    end
    data_o = ecc_extract(fixed);
  end
endmodule

// File: rtl/sram_ecc_ctrl.sv
module sram_ecc_ctrl
  import sram_ecc_pkg::*;
#(
  parameter  int unsigned ADDR_W = 32,
  parameter  int unsigned DEPTH  = 256,
  localparam int unsigned IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              split_i,
  input  logic [ADDR_W-1:0] base0_i,
  input  logic [ADDR_W-1:0] base1_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [7:0]        req_be_i,
  input  logic [63:0]       req_wdata_i,
  output logic              rsp_valid_o,
  output logic [63:0]       rsp_rdata_o,
  output logic              corr_err_o,
  output logic              uncorr_err_o,
  input  logic              bd_flip_i,
  input  logic [IDX_W-1:0]  bd_idx_i,
  input  logic [6:0]        bd_bit_i
);
  state_e             state_q, state_d;
  logic               hit;
  logic [IDX_W-1:0]   idx, idx_q, wr_idx;
  logic [63:0]        wdata_q, merged, dec_data, enc_in, rdata_q;
  logic [7:0]         be_q;
  logic               accept, full_wr, rd_en, wr_en, busy;
  logic               dec_single, dec_double;
  logic               rsp_valid_q, corr_q, uncorr_q;
  code_t              rd_code, enc_code;

  sram_ecc_region_dec #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec_addr (
    .addr_i (req_addr_i),
    .split_i(split_i),
    .base0_i(base0_i),
    .base1_i(base1_i),
    .hit_o  (hit),
    .idx_o  (idx)
  );

  sram_ecc_dec u_dec_ecc (
    .code_i  (rd_code),
    .data_o  (dec_data),
    .single_o(dec_single),
    .double_o(dec_double)
  );

  assign busy        = state_q != ST_IDLE;
  assign req_ready_o = !busy;
  assign accept      = req_valid_i && req_ready_o && hit;
  assign full_wr     = accept && req_write_i && (&req_be_i);
  assign rd_en       = accept && !(req_write_i && (&req_be_i));

  always_comb begin
    for (int b = 0; b < 8; b++) begin
      merged[8*b +: 8] = be_q[b] ? wdata_q[8*b +: 8] : dec_data[8*b +: 8];
    end
  end

  // one shared encoder: bus data when idle, merged word during RMW
  assign enc_in   = (state_q == ST_MERGE) ? merged : req_wdata_i;
  assign enc_code = ecc_encode(enc_in);
  assign wr_en    = full_wr || (state_q == ST_MERGE && !dec_double);
  assign wr_idx   = (state_q == ST_MERGE) ? idx_q : idx;

  sram_ecc_array #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_array (
    .clk_i    (clk_i),
    .wr_en_i  (wr_en),
    .wr_idx_i (wr_idx),
    .wr_code_i(enc_code),
    .rd_en_i  (rd_en),
    .rd_idx_i (idx),
    .rd_code_o(rd_code),
    .bd_flip_i(bd_flip_i),
    .bd_idx_i (bd_idx_i),
    .bd_bit_i (bd_bit_i)
  );

  always_comb begin
    state_d = ST_IDLE;
    if (state_q == ST_IDLE && rd_en) state_d = req_write_i ? ST_MERGE : ST_READ;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      wdata_q     <= '0;
      be_q        <= '0;
      rsp_valid_q <= 1'b0;
      rdata_q     <= '0;
      corr_q      <= 1'b0;
      uncorr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (rd_en) begin
        idx_q   <= idx;
        wdata_q <= req_wdata_i;
        be_q    <= req_be_i;
      end
      rsp_valid_q <= full_wr || busy;
      rdata_q     <= (state_q == ST_READ) ? dec_data : '0;
      corr_q      <= busy && dec_single;
      uncorr_q    <= busy && dec_double;
    end
  end

  assign rsp_valid_o  = rsp_valid_q;
  assign rsp_rdata_o  = rdata_q;
  assign corr_err_o   = corr_q;
  assign uncorr_err_o = uncorr_q;
endmodule

// File: rtl/sram_ecc_ctrl_chk.sv
module sram_ecc_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic       req_ready_o,
  input logic       req_write_i,
  input logic [7:0] req_be_i,
  input logic       hit,
  input logic       rsp_valid_o,
  input logic       corr_err_o,
  input logic       uncorr_err_o
);
  p_read_latency_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && hit && !req_write_i) |=> (!req_ready_o && !rsp_valid_o) ##1 rsp_valid_o);

  p_full_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && hit && req_write_i && (&req_be_i)) |=>
      (rsp_valid_o && req_ready_o && !corr_err_o && !uncorr_err_o));

  p_rmw_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && hit && req_write_i && !(&req_be_i)) |=>
      !req_ready_o ##1 (rsp_valid_o && req_ready_o));

  p_busy_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |=> req_ready_o);

  p_unclaimed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !hit) |=> (!rsp_valid_o && req_ready_o));

  p_flag_with_rsp_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (corr_err_o || uncorr_err_o) |-> rsp_valid_o);

  p_flag_excl_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(corr_err_o && uncorr_err_o));
endmodule

bind sram_ecc_ctrl sram_ecc_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_write_i (req_write_i),
  .req_be_i    (req_be_i),
  .hit         (hit),
  .rsp_valid_o (rsp_valid_o),
  .corr_err_o  (corr_err_o),
  .uncorr_err_o(uncorr_err_o)
);

// File: tb/tb_sram_ecc_ctrl.sv
module tb_sram_ecc_ctrl;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DEPTH  = 256;
  localparam int unsigned IDX_W  = $clog2(DEPTH);
  localparam int unsigned HALF   = DEPTH / 2;
  localparam logic [31:0] B0     = 32'h4000_0000;
  localparam logic [31:0] B1     = 32'h8000_0400;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              split = 1'b0;
  logic [31:0]       base0 = B0, base1 = B1;
  logic              req_valid = 1'b0, req_write = 1'b0;
  logic [31:0]       req_addr = '0;
  logic [7:0]        req_be = '0;
  logic [63:0]       req_wdata = '0;
  logic              req_ready, rsp_valid, corr, uncorr;
  logic [63:0]       rsp_rdata;
  logic              bd_flip = 1'b0;
  logic [IDX_W-1:0]  bd_idx = '0;
  logic [6:0]        bd_bit = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [63:0] model [DEPTH];

  always #5 clk = ~clk;

  sram_ecc_ctrl #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .split_i(split), .base0_i(base0), .base1_i(base1),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_be_i(req_be), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .corr_err_o(corr),
    .uncorr_err_o(uncorr), .bd_flip_i(bd_flip), .bd_idx_i(bd_idx), .bd_bit_i(bd_bit)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] merge(logic [63:0] old, logic [63:0] nw, logic [7:0] be);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[8*b +: 8] = be[b] ? nw[8*b +: 8] : old[8*b +: 8];
    return r;
  endfunction

  function automatic logic [31:0] addr_of(int unsigned idx, logic sp, logic [2:0] lsb);
    logic [31:0] a;
    if (!sp)            a = B0 + 32'(idx) * 8;
    else if (idx < HALF) a = B0 + 32'(idx) * 8;
    else                a = B1 + 32'(idx - HALF) * 8;
    return {a[31:3], lsb};
  endfunction

  // lat: 1 = response at first sample, 2 = one cycle later, 0 = none
  task automatic access(input logic wr, input logic [31:0] a, input logic [63:0] wd,
                        input logic [7:0] be, output int lat, output logic busy,
                        output logic [63:0] rd, output logic c, output logic u);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; req_be = be;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    lat = 0; rd = '0; c = 1'b0; u = 1'b0;
    busy = !req_ready;
    if (rsp_valid) begin
      lat = 1; rd = rsp_rdata; c = corr; u = uncorr;
    end else begin
      @(negedge clk);
      if (rsp_valid) begin
        lat = 2; rd = rsp_rdata; c = corr; u = uncorr;
      end
    end
  endtask

  task automatic flip(input int unsigned idx, input int unsigned bitn);
    bd_flip = 1'b1; bd_idx = IDX_W'(idx); bd_bit = 7'(bitn);
    @(posedge clk); @(negedge clk);
    bd_flip = 1'b0;
  endtask

  task automatic read_chk(input int unsigned idx, input logic [63:0] exp, input logic ec,
                          input logic eu, input string tag);
    int lat; logic busy, c, u; logic [63:0] rd;
    access(1'b0, addr_of(idx, split, 3'($urandom_range(0, 7))), '0, '0, lat, busy, rd, c, u);
    chk(lat == 2 && busy, {tag, " latency"}, 64'(lat), 64'd2);
    chk(rd == exp, {tag, " data"}, rd, exp);
    chk(c == ec && u == eu, {tag, " flags (R12)"}, {c, u}, {ec, eu});
  endtask

  task automatic write_full(input int unsigned idx, input logic [63:0] d, input string tag);
    int lat; logic busy, c, u; logic [63:0] rd;
    access(1'b1, addr_of(idx, split, 3'd0), d, 8'hFF, lat, busy, rd, c, u);
    chk(lat == 1 && !busy && !c && !u, tag, {busy, c, u, 8'(lat)}, 64'd1);
    model[idx] = d;
  endtask

  task automatic write_part(input int unsigned idx, input logic [63:0] d, input logic [7:0] be,
                            input logic ec, input logic eu, input string tag);
    int lat; logic busy, c, u; logic [63:0] rd;
    access(1'b1, addr_of(idx, split, 3'd0), d, be, lat, busy, rd, c, u);
    chk(lat == 2 && busy, {tag, " latency"}, 64'(lat), 64'd2);
    chk(c == ec && u == eu, {tag, " flags"}, {c, u}, {ec, eu});
    if (!eu) model[idx] = merge(model[idx], d, be);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog act=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int lat; logic busy, c, u; logic [63:0] rd, d, old;
    void'($urandom(32'd2024));
    @(negedge clk);
    chk(req_ready && !rsp_valid && !corr && !uncorr, "R11 reset outputs",
        {req_ready, rsp_valid, corr, uncorr}, 64'b1000);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk(req_ready && !rsp_valid, "R11 after reset", {req_ready, rsp_valid}, 64'b10);

    // R9/R2: fill the whole single window
    for (int i = 0; i < DEPTH; i++) write_full(i, {$urandom, $urandom}, "R2 full write");
    for (int i = 0; i < 8; i++) read_chk(i * 37 % DEPTH, model[i * 37 % DEPTH], 0, 0, "R9 read");

    // R3 directed byte merges
    write_part(4, 64'hA1A2_A3A4_A5A6_A7A8, 8'h01, 0, 0, "R3 low byte");
    read_chk(4, model[4], 0, 0, "R3 low byte readback");
    write_part(5, 64'hB1B2_B3B4_B5B6_B7B8, 8'h80, 0, 0, "R3 high byte");
    read_chk(5, model[5], 0, 0, "R3 high byte readback");
    write_part(6, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00, 0, 0, "R3 empty mask");
    read_chk(6, model[6], 0, 0, "R3 empty mask readback");

    // random mix over both address modes
    for (int i = 0; i < 400; i++) begin
      int unsigned idx, op;
      split = 1'($urandom_range(0, 1));
      idx = $urandom_range(0, DEPTH - 1);
      op = $urandom_range(0, 9);
      d = {$urandom, $urandom};
      if (op < 2) begin
        access(1'($urandom_range(0, 1)), 32'h2000_0000 + 32'(idx) * 8, d, 8'hFF, lat, busy, rd, c, u);
        chk(lat == 0 && !busy, "R8 random unclaimed", 64'(lat), 64'd0);
      end else if (op < 5) read_chk(idx, model[idx], 0, 0, "R1 random read");
      else if (op < 7) write_full(idx, d, "R2 random full write");
      else write_part(idx, d, 8'($urandom_range(0, 254)), 0, 0, "R3 random partial");
    end
    for (int i = 0; i < DEPTH; i += 17) read_chk(i, model[i], 0, 0, "R10 mixed-mode readback");

    // R10: upper half via base1, then seen in single mode
    split = 1'b1;
    write_full(HALF + 5, 64'h1234_5678_9ABC_DEF0, "R10 split write");
    split = 1'b0;
    read_chk(HALF + 5, 64'h1234_5678_9ABC_DEF0, 0, 0, "R10 split alias");
    // overlapping bases: base0 wins
    split = 1'b1; base1 = B0; old = model[HALF + 3];
    access(1'b1, B0 + 32'd24, 64'h0BAD_CAFE_0000_0003, 8'hFF, lat, busy, rd, c, u);
    model[3] = 64'h0BAD_CAFE_0000_0003;
    base1 = B1; split = 1'b0;
    read_chk(3, model[3], 0, 0, "R10 priority low");
    read_chk(HALF + 3, old, 0, 0, "R10 priority upper untouched");

    // R8: outside windows leaves storage alone
    access(1'b1, B0 + DEPTH * 8 + 32'd56, 64'hDEAD, 8'hFF, lat, busy, rd, c, u);
    chk(lat == 0, "R8 beyond window", 64'(lat), 64'd0);
    read_chk(7, model[7], 0, 0, "R8 word unchanged");
    split = 1'b1;
    access(1'b1, B0 + HALF * 8 + 32'd8, 64'hDEAD, 8'h0F, lat, busy, rd, c, u);
    chk(lat == 0, "R8 split gap", 64'(lat), 64'd0);
    split = 1'b0;
    read_chk(1, model[1], 0, 0, "R8 split gap word unchanged");
    read_chk(HALF + 1, model[HALF + 1], 0, 0, "R8 split gap upper unchanged");

    // R4 single faults, incl. overall parity bit and last bit
    foreach (model[k]) if (k == 0) begin end
    for (int j = 0; j < 4; j++) begin
      int unsigned bp;
      bp = (j == 0) ? 0 : (j == 1) ? 71 : (j == 2) ? 37 : 4;
      flip(10, bp);
      read_chk(10, model[10], 1, 0, "R4 single correct");
      flip(10, bp);
    end
    read_chk(10, model[10], 0, 0, "R4 clean after restore");

    // R5 double fault
    flip(11, 3); flip(11, 50);
    begin
      access(1'b0, addr_of(11, 1'b0, 3'd0), '0, '0, lat, busy, rd, c, u);
      chk(lat == 2 && u && !c, "R5 double detect", {c, u}, 64'b01);
    end
    flip(11, 3); flip(11, 50);
    read_chk(11, model[11], 0, 0, "R5 clean after restore");

    // R6 scrub through RMW
    flip(12, 20);
    write_part(12, 64'h5555_6666_7777_8888, 8'h0F, 1, 0, "R6 rmw corrected");
    read_chk(12, model[12], 0, 0, "R6 scrubbed");

    // R7 abort on double fault
    old = model[13];
    flip(13, 9); flip(13, 66);
    write_part(13, 64'hFFFF_0000_FFFF_0000, 8'hF0, 0, 1, "R7 rmw abort");
    flip(13, 9); flip(13, 66);
    read_chk(13, old, 0, 0, "R7 word unchanged");

    // R2 full write ignores a corrupt old word
    flip(14, 2); flip(14, 40);
    write_full(14, 64'hC0FF_EE00_1122_3344, "R2 overwrite corrupt");
    read_chk(14, model[14], 0, 0, "R2 overwrite readback");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule